// File: doc/BRIEF.md
# Request Arbiter and Byte-Transfer Sequencer

This block sits between a set of peripheral request lines and the system bus. It combines hardware request lines with a small software request register and filters the result through a per-channel mask. When a request is waiting, it asks the host for the bus. Once the host grants the bus, it picks one channel and runs byte-sized transfer cycles for that channel. Each cycle drives the channel's address, the read and write strobes and that channel's acknowledge line.

A separate channel unit owns the per-channel address and count registers. The sequencer reads the current address from that unit. It sends the unit a step pulse once per byte and stops when the unit reports that the count is exhausted. In I/O mode the data goes straight from the source to the destination, because the memory and I/O strobes are raised together.

For memory-to-memory moves, channel 0 supplies the source and channel 1 the destination. The byte is held in an internal temporary register between the read half and the write half. In fill mode the source address is never stepped, so a single byte is copied across the whole destination range.

Top module: `xfer_sequencer`

## Requirements
- R1: After reset, and whenever the bus is not requested, all of these are low: `bus_req`, `bus_oe`, `data_oe`, every `dack` and `step` bit, and all four strobes. `addr_out` and `data_out` read zero when not driven.
- R2: The effective request of channel i is `(hw_req[i] | sw_req[i]) & ~chan_mask[i]`, where a mask bit of 1 blocks the channel. Blocked requests never raise `bus_req`. Blocked requests are held, not lost: a pending software request is served once its mask bit clears.
- R3: An effective request seen while idle raises `bus_req` one cycle later. The block does not drive the bus (`bus_oe`, `dack`) until it samples `bus_gnt` high. The first transfer state follows the cycle in which the grant is sampled.
- R4: When several channels request at once, the lowest-numbered channel wins. The choice is made at the grant.
- R5: An I/O byte takes four states, S1 to S4. Throughout all four, `dack` is one-hot on the selected channel, `bus_oe` is high and `addr_out` carries that channel's address. The strobes are active only in S3 and S4. If `dir_to_io` is 1, `mem_rd` and `io_wr` are active together; if it is 0, `io_rd` and `mem_wr` are active together.
- R6: `step` pulses for exactly one cycle on the selected channel, during S4 of each byte.
- R7: If `tc` of the selected channel is high at the end of S4, the block returns to idle and `bus_req` drops in the next cycle. Otherwise, in block mode (`demand_mode` = 0), the next byte starts on the same channel even if the request has gone.
- R8: In demand mode (`demand_mode` = 1), if the channel's effective request is low at the end of S4, the block returns to idle after that byte.
- R9: Each bit of `sw_set` is a one-cycle pulse that sets the channel's software request. That bit clears by itself when the channel finishes a transfer on terminal count.
- R10: In memory-to-memory mode (`m2m_en`), only channel 0's request starts a move. Each byte has two halves of four states each, and `dack`, `io_rd` and `io_wr` stay low throughout. In the read half, `addr_out` shows channel 0's address and `mem_rd` is active in S3 and S4. The block stores `data_in` at the end of that S4. In the write half, `addr_out` shows channel 1's address, `data_oe` is high, `data_out` shows the stored byte and `mem_wr` is active in S3 and S4.
- R11: In a memory-to-memory move, `step[0]` pulses in the read-half S4 and `step[1]` in the write-half S4. `tc[1]` at the end of the write half ends the move and clears the software requests of channels 0 and 1.
- R12: When `fill_en` is set, `step[0]` never pulses during a memory-to-memory move. The source address therefore stays fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 4 | Hardware request lines, one per channel |
| chan_mask | input | 4 | Per-channel mask, 1 blocks the channel |
| sw_set | input | 4 | Pulse to set a software request |
| demand_mode | input | 1 | 1: stop when the request drops; 0: run to terminal count |
| dir_to_io | input | 1 | 1: memory to I/O; 0: I/O to memory |
| m2m_en | input | 1 | Memory-to-memory mode (channel 0 source, channel 1 destination) |
| fill_en | input | 1 | Hold the source address during memory-to-memory moves |
| bus_req | output | 1 | Request for the system bus |
| bus_gnt | input | 1 | Host grant of the system bus |
| chan_addr | input | 64 | Current address of each channel, channel i in bits [16i+15:16i] |
| tc | input | 4 | Terminal count indication from the channel unit |
| step | output | 4 | Advance the address and count of one channel |
| dack | output | 4 | Acknowledge to the served peripheral |
| bus_oe | output | 1 | Bus outputs driven; low means released (high impedance) |
| addr_out | output | 16 | Transfer address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| data_in | input | 8 | Data bus input, captured during a memory-to-memory read |
| data_out | output | 8 | Stored byte during a memory-to-memory write |
| data_oe | output | 1 | Data bus driven |

## Verification
The assertions check several properties on every cycle:
- the bus stays quiet while it is not requested (R1);
- the outputs are enabled only after a sampled grant (R3);
- `dack` and `step` are at most one-hot (R5, R6);
- a strobe pair never mixes a fly-by I/O strobe with the wrong memory strobe (R5);
- a step pulse occurs only inside a strobe phase (R6);
- memory-to-memory writes never carry an acknowledge or an I/O strobe (R10).

Only the bench scenarios can show the behaviours that depend on which channel, address or byte is correct. These are the lowest-index priority choice under random request and mask patterns, the exact state in which the strobes and step appear, and the return to idle on terminal count versus a dropped demand request. They also include the software request clearing itself and the stored byte surviving a changed data bus, as well as the source address being held in fill mode.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_S1,
    ST_S2,
    ST_S3,
    ST_S4
  } seq_state_t;
endpackage

// File: rtl/xfer_req_merge.sv
module xfer_req_merge #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] sw_set,
  input  logic [NCH-1:0] sw_clr,
  output logic [NCH-1:0] eff,
  output logic           any,
  output logic [IW-1:0]  win_idx
);
  logic [NCH-1:0] sw_q, sw_d;

  // set wins over clear when both arrive in one cycle
  always_comb sw_d = (sw_q & ~sw_clr) | sw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= sw_d;
  end

  assign eff = (hw_req | sw_q) & ~chan_mask;
  assign any = |eff;

  // fixed priority: lowest index wins
  always_comb begin
    win_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eff[i]) win_idx = IW'(i);
    end
  end
endmodule

// File: rtl/xfer_temp_reg.sv
module xfer_temp_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xfer_cycle_ctl.sv
module xfer_cycle_ctl
  import xfer_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pend,
  input  logic [NCH-1:0] eff,
  input  logic [IW-1:0]  win_idx,
  input  logic           gnt,
  input  logic [NCH-1:0] tc,
  input  logic           demand_mode,
  input  logic           dir_to_io,
  input  logic           m2m_en,
  input  logic           fill_en,
  output logic           bus_req,
  output logic           bus_oe,
  output logic [NCH-1:0] dack,
  output logic [NCH-1:0] step,
  output logic [NCH-1:0] sw_clr,
  output logic           load_tmp,
  output logic [IW-1:0]  addr_idx,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic           data_oe
);
  seq_state_t st_q, st_d;
  logic [IW-1:0] sel_q, sel_d;
  logic ph_q, ph_d;
  logic mm_q, fill_q, dir_q;
  logic mode_ld;
  logic active, strb, io_act, in_s4;

  assign mode_ld = (st_q == ST_WAIT) && pend && gnt;

  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    ph_d     = ph_q;
    sw_clr   = '0;
    load_tmp = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pend) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!pend) st_d = ST_IDLE;
        else if (gnt) begin
          st_d  = ST_S1;
          sel_d = m2m_en ? '0 : win_idx;
          ph_d  = 1'b0;
        end
      end
      ST_S1: st_d = ST_S2;
      ST_S2: st_d = ST_S3;
      ST_S3: st_d = ST_S4;
      ST_S4: begin
        if (mm_q) begin
          if (!ph_q) begin
            load_tmp = 1'b1;
            ph_d     = 1'b1;
            st_d     = ST_S1;
          end else begin
            ph_d = 1'b0;
            if (tc[1]) begin
              sw_clr[0] = 1'b1;
              sw_clr[1] = 1'b1;
              st_d      = ST_IDLE;
            end else st_d = ST_S1;
          end
        end else if (tc[sel_q]) begin
          sw_clr[sel_q] = 1'b1;
          st_d          = ST_IDLE;
        end else if (demand_mode && !eff[sel_q]) st_d = ST_IDLE;
        else st_d = ST_S1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      ph_q  <= ph_d;
    end
  end

  // mode captured once per bus tenure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_q   <= 1'b0;
      fill_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (mode_ld) begin
      mm_q   <= m2m_en;
      fill_q <= fill_en;
      dir_q  <= dir_to_io;
    end
  end

  assign active  = (st_q == ST_S1) || (st_q == ST_S2) || (st_q == ST_S3) || (st_q == ST_S4);
  assign strb    = (st_q == ST_S3) || (st_q == ST_S4);
  assign in_s4   = (st_q == ST_S4);
  assign io_act  = active && !mm_q;
  assign bus_req = (st_q != ST_IDLE);
  assign bus_oe  = active;
  assign data_oe = active && mm_q && ph_q;
  assign mem_rd  = strb && (mm_q ? !ph_q : dir_q);
  assign mem_wr  = strb && (mm_q ? ph_q : !dir_q);
  assign io_rd   = strb && !mm_q && !dir_q;
  assign io_wr   = strb && !mm_q && dir_q;
  assign addr_idx = mm_q ? IW'(ph_q) : sel_q;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam logic [IW-1:0] IDX = IW'(i);
    assign dack[i] = io_act && (sel_q == IDX);
    if (i == 0) begin : g_src
      assign step[i] = in_s4 && (mm_q ? (!ph_q && !fill_q) : (sel_q == IDX));
    end else if (i == 1) begin : g_dst
      assign step[i] = in_s4 && (mm_q ? ph_q : (sel_q == IDX));
    end else begin : g_oth
      assign step[i] = in_s4 && !mm_q && (sel_q == IDX);
    end
  end
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hw_req,
  input  logic [NCH-1:0]    chan_mask,
  input  logic [NCH-1:0]    sw_set,
  input  logic              demand_mode,
  input  logic              dir_to_io,
  input  logic              m2m_en,
  input  logic              fill_en,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic [NCH*AW-1:0] chan_addr,
  input  logic [NCH-1:0]    tc,
  output logic [NCH-1:0]    step,
  output logic [NCH-1:0]    dack,
  output logic              bus_oe,
  output logic [AW-1:0]     addr_out,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  input  logic [DW-1:0]     data_in,
  output logic [DW-1:0]     data_out,
  output logic              data_oe
);
  logic [1:0] rst_sync;
  logic rst_i_n;
  logic [NCH-1:0] eff, sw_clr;
  logic any, pend, load_tmp;
  logic [IW-1:0] win_idx, addr_idx;
  logic [DW-1:0] tmp_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  xfer_req_merge #(.NCH(NCH)) u_req (
    .clk(clk), .rst_n(rst_i_n), .hw_req(hw_req), .chan_mask(chan_mask),
    .sw_set(sw_set), .sw_clr(sw_clr), .eff(eff), .any(any), .win_idx(win_idx)
  );

  assign pend = m2m_en ? eff[0] : any;

  xfer_cycle_ctl #(.NCH(NCH)) u_ctl (
    .clk(clk), .rst_n(rst_i_n), .pend(pend), .eff(eff), .win_idx(win_idx),
    .gnt(bus_gnt), .tc(tc), .demand_mode(demand_mode), .dir_to_io(dir_to_io),
    .m2m_en(m2m_en), .fill_en(fill_en), .bus_req(bus_req), .bus_oe(bus_oe),
    .dack(dack), .step(step), .sw_clr(sw_clr), .load_tmp(load_tmp),
    .addr_idx(addr_idx), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .data_oe(data_oe)
  );

  xfer_temp_reg #(.DW(DW)) u_tmp (
    .clk(clk), .rst_n(rst_i_n), .load(load_tmp), .d(data_in), .q(tmp_q)
  );

  assign addr_out = bus_oe  ? chan_addr[addr_idx*AW +: AW] : '0;
  assign data_out = data_oe ? tmp_q : '0;
endmodule

// File: rtl/xfer_sequencer_chk.sv
module xfer_sequencer_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           bus_oe,
  input logic [NCH-1:0] dack,
  input logic [NCH-1:0] step,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr,
  input logic           data_oe
);
  a_r1_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (!bus_oe && !data_oe && dack == '0 && step == '0 &&
                  !mem_rd && !mem_wr && !io_rd && !io_wr));

  a_r3_drive_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(bus_gnt));

  a_r5_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  a_r5_flyby_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    !((io_wr && !mem_rd) || (io_rd && !mem_wr)));

  a_r6_step_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step));

  a_r6_step_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (|step) |-> (mem_rd || mem_wr));

  a_r10_m2m_no_io: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (dack == '0 && !io_rd && !io_wr));

  a_r10_no_rd_wr_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind xfer_sequencer xfer_sequencer_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_oe(bus_oe), .dack(dack), .step(step), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .data_oe(data_oe)
);

// File: tb/tb_xfer_sequencer.sv
module tb_xfer_sequencer;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] hw_req, chan_mask, sw_set, tc, step, dack;
  logic demand_mode, dir_to_io, m2m_en, fill_en, bus_req, bus_gnt, bus_oe;
  logic [NCH*AW-1:0] chan_addr;
  logic [AW-1:0] addr_out;
  logic mem_rd, mem_wr, io_rd, io_wr, data_oe;
  logic [DW-1:0] data_in, data_out;
  logic [3:0] strb;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xfer_sequencer #(.NCH(NCH), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .chan_mask(chan_mask),
    .sw_set(sw_set), .demand_mode(demand_mode), .dir_to_io(dir_to_io),
    .m2m_en(m2m_en), .fill_en(fill_en), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .chan_addr(chan_addr), .tc(tc), .step(step), .dack(dack), .bus_oe(bus_oe),
    .addr_out(addr_out), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
  );

  assign strb = {mem_rd, mem_wr, io_rd, io_wr};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(logic [NCH-1:0] v);
    for (int i = 0; i < NCH; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [AW-1:0] addr_of(int ch);
    return chan_addr[ch*AW +: AW];
  endfunction

  function automatic logic [3:0] pair(bit dir);
    return dir ? 4'b1001 : 4'b0110;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // precondition: sampled in S1 of an I/O byte
  task automatic io_byte(string tag, int ch, bit dir, bit last, bit drop);
    check({tag, " dack S1"}, dack, 32'(1 << ch));
    check({tag, " addr S1"}, addr_out, addr_of(ch));
    check({tag, " oe S1"}, bus_oe, 1);
    check({tag, " strobes S1"}, strb, 0);
    tick();
    check({tag, " strobes S2"}, strb, 0);
    check({tag, " dack S2"}, dack, 32'(1 << ch));
    tick();
    check({tag, " strobes S3"}, strb, pair(dir));
    check("R6 no step S3", step, 0);
    tick();
    check({tag, " strobes S4"}, strb, pair(dir));
    check("R6 step S4", step, 32'(1 << ch));
    tc[ch] = last;
    if (drop) hw_req[ch] = 1'b0;
    tick();
    tc = '0;
  endtask

  // precondition: sampled in S1 of the read half
  task automatic m2m_byte(logic [7:0] b, bit fill, bit last);
    data_in = b;
    check("R10 src addr", addr_out, addr_of(0));
    check("R10 no dack", dack, 0);
    check("R10 rd S1 strobes", strb, 0);
    tick(); tick();
    check("R10 rd S3 strobe", strb, 4'b1000);
    tick();
    check("R10 rd S4 strobe", strb, 4'b1000);
    check(fill ? "R12 src held" : "R11 src step", step, fill ? 0 : 1);
    tick();
    data_in = ~b;
    check("R10 dst addr", addr_out, addr_of(1));
    check("R10 data_oe", data_oe, 1);
    check("R10 temp byte", data_out, b);
    tick(); tick();
    check("R10 wr S3 strobe", strb, 4'b0100);
    check("R10 temp held", data_out, b);
    tick();
    check("R10 wr S4 strobe", strb, 4'b0100);
    check("R11 dst step", step, 2);
    tc[1] = last;
    tick();
    tc = '0;
  endtask

  task automatic grant_now();
    check("R3 bus_req", bus_req, 1);
    bus_gnt = 1'b1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; hw_req = '0; chan_mask = '0; sw_set = '0; tc = '0;
    demand_mode = 0; dir_to_io = 0; m2m_en = 0; fill_en = 0; bus_gnt = 0;
    data_in = '0;
    for (int i = 0; i < NCH; i++) chan_addr[i*AW +: AW] = AW'(16'h1100 * (i + 1));
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    check("R1 bus_req", bus_req, 0);
    check("R1 oe", {bus_oe, data_oe}, 0);
    check("R1 dack/step", {dack, step}, 0);
    check("R1 strobes", strb, 0);
    check("R1 addr", addr_out, 0);
    check("R1 data", data_out, 0);

    // R2 masked hardware request ignored
    hw_req = 4'b0001; chan_mask = 4'b0001;
    repeat (3) tick();
    check("R2 masked", bus_req, 0);
    hw_req = '0; chan_mask = '0;

    // R3/R5/R7 block transfer on channel 2, grant delayed
    hw_req = 4'b0100; dir_to_io = 1;
    tick();
    check("R3 req raised", bus_req, 1);
    tick();
    check("R3 no drive before grant", {bus_oe, dack}, 0);
    check("R3 still requesting", bus_req, 1);
    bus_gnt = 1'b1;
    tick();
    io_byte("R5 b0", 2, 1, 0, 0);
    io_byte("R5 b1", 2, 1, 0, 0);
    io_byte("R7 b2", 2, 1, 1, 0);
    check("R7 idle after tc", bus_req, 0);
    hw_req = '0; bus_gnt = 0;
    tick();

    // R4 random request and mask patterns
    for (int it = 0; it < 24; it++) begin
      logic [NCH-1:0] r, m, e;
      bit d;
      r = NCH'($urandom); m = NCH'($urandom) & NCH'($urandom); d = 1'($urandom);
      for (int i = 0; i < NCH; i++) chan_addr[i*AW +: AW] = AW'($urandom);
      e = r & ~m;
      hw_req = r; chan_mask = m; dir_to_io = d;
      tick();
      if (e == 0) begin
        tick();
        check("R2 masked random", bus_req, 0);
      end else begin
        grant_now();
        io_byte("R4 winner", lowest(e), d, 1, 0);
        check("R7 idle", bus_req, 0);
      end
      hw_req = '0; chan_mask = '0; bus_gnt = 0;
      tick();
    end

    // R8 demand mode stops when request drops
    demand_mode = 1; dir_to_io = 0; hw_req = 4'b0010;
    tick(); grant_now();
    io_byte("R8 demand", 1, 0, 0, 1);
    check("R8 idle on drop", bus_req, 0);
    bus_gnt = 0; demand_mode = 0;
    tick();
    // R7 block mode continues after drop
    hw_req = 4'b0010;
    tick(); grant_now();
    io_byte("R7 block", 1, 0, 0, 1);
    check("R7 continues", dack, 2);
    io_byte("R7 block end", 1, 0, 1, 0);
    check("R7 idle", bus_req, 0);
    bus_gnt = 0;
    tick();

    // R9 software request, auto-clear at tc
    sw_set = 4'b1000; dir_to_io = 1;
    tick(); sw_set = '0;
    tick(); grant_now();
    io_byte("R9 sw", 3, 1, 1, 0);
    bus_gnt = 0;
    repeat (3) tick();
    check("R9 sw cleared", bus_req, 0);
    // R2 masked software request is held
    chan_mask = 4'b0100; sw_set = 4'b0100;
    tick(); sw_set = '0;
    repeat (3) tick();
    check("R2 masked sw", bus_req, 0);
    chan_mask = '0;
    tick(); grant_now();
    io_byte("R2 sw released", 2, 1, 1, 0);
    bus_gnt = 0;
    repeat (2) tick();
    check("R9 sw cleared ch2", bus_req, 0);

    // R10/R11 memory-to-memory
    chan_addr[0 +: AW] = 16'h1234; chan_addr[AW +: AW] = 16'h5678;
    m2m_en = 1; hw_req = 4'b0100;
    repeat (2) tick();
    check("R10 only ch0 starts", bus_req, 0);
    hw_req = '0; sw_set = 4'b0001;
    tick(); sw_set = '0;
    tick(); grant_now();
    m2m_byte(8'hA5, 0, 0);
    m2m_byte(8'h3C, 0, 1);
    check("R11 idle on tc1", bus_req, 0);
    bus_gnt = 0;
    repeat (2) tick();
    check("R11 sw0 cleared", bus_req, 0);

    // R12 fill
    fill_en = 1; sw_set = 4'b0001;
    tick(); sw_set = '0;
    tick(); grant_now();
    m2m_byte(8'h5A, 1, 0);
    m2m_byte(8'hC3, 1, 1);
    check("R12 idle", bus_req, 0);
    bus_gnt = 0; m2m_en = 0; fill_en = 0;
    repeat (2) tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule